// File: doc/BRIEF.md
# Match-Clear Up-Counter with External Clear Pin

This block is a 16-bit up-counter with a software-loaded compare register. On each count event the counter either steps up by one or, when it already equals the compare value, returns to zero and sets a sticky match flag. A count event comes from one of two sources. The first is a single-cycle enable from a power-of-two divider on the system clock. The second is a rising edge on an external count pin. A run bit gates both sources.

A second external pin can clear the counter at any time when its enable bit is set. It acts on a falling edge and records the event in its own sticky flag. Both flags drive one interrupt output, gated by an interrupt-enable bit.

Software reaches the block through a two-bit address. A write port loads the count, compare, control and flag registers, and a combinational read port returns them.

Top module: `mrt_timer`

## Requirements
- R1: Register addresses are 0 = count, 1 = compare, 2 = control, 3 = flags. Control bits are: bit0 run, bit1 source select, bit2 clear-pin enable, bit3 interrupt enable, bits 6:4 divider exponent N. Flag bits are: bit0 match, bit1 clear-pin event. Reset leaves count 0, compare FFFFh, control 0, flags 0 and the interrupt low.
- R2: With run = 1, each count event raises the count by one, starting from whatever value the count register holds.
- R3: When a count event arrives while count equals compare, the count becomes 0 on that edge and the match flag is set. The count sequence therefore repeats every compare+1 events.
- R4: Control bit1 = 0 selects the divided system clock as the count source. Control bit1 = 1 selects rising edges on the count pin, and the divider setting then has no effect.
- R5: The divider issues one count event every 2^N system clocks. After run is set on clock edge E0, the events land on edges E0 + k·2^N for k ≥ 1.
- R6: With run = 0 the count holds its value.
- R7: Both pins pass through two synchronizer flops. A pin change made before clock edge A takes effect on the count at the edge two after A. A held level counts only once.
- R8: With control bit2 = 1, a falling edge on the clear pin forces the count to 0 and sets the clear-pin flag, whether or not run is set. With bit2 = 0 the pin has no effect on count or flags.
- R9: Flags are sticky. A write to address 3 loads both flag bits from wr_data[1:0]. If a match and a clear-pin event fall on the same edge, both flags are set and the count becomes 0.
- R10: irq is high exactly when control bit3 = 1 and at least one flag is set.
- R11: A software write to the count register overrides counting and clearing on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register select |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read register select |
| rd_data | output | 16 | Read data, combinational |
| cnt_pin | input | 1 | External count pin, rising edges counted |
| clr_pin | input | 1 | External clear pin, falling edges act |
| irq | output | 1 | Interrupt request |

## Verification
Register writes show on the read port right after the writing edge. Divided-clock events are due on edges E0 + k·2^N, so the bench holds a run for a fixed number of edges and predicts the count as floor(W/2^N) mod (compare+1). Pin stimuli are applied between edges, and the result is sampled on the falling clock after the second edge past the first sampling edge. The edge before that is also sampled to confirm the value has not yet changed. The coincident match and clear case times the pin fall so that its detected edge lands on the same edge as the compare match.

// File: rtl/mrt_pkg.sv
package mrt_pkg;
    localparam int CNT_W  = 16;
    localparam int PS_W   = 3;
    localparam int PCNT_W = (1 << PS_W) - 1;

    typedef enum logic [1:0] {
        SEL_COUNT = 2'd0,
        SEL_CMP   = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_FLAGS = 2'd3
    } reg_sel_e;

    // bit0 run, bit1 src_ext, bit2 clr_en, bit3 irq_en, bits 6:4 div
    typedef struct packed {
        logic [PS_W-1:0] div;
        logic            irq_en;
        logic            clr_en;
        logic            src_ext;
        logic            run;
    } ctrl_t;

    // bit0 match, bit1 clear-pin event
    typedef struct packed {
        logic clr;
        logic match;
    } flags_t;

    function automatic logic [PCNT_W-1:0] div_mask(input logic [PS_W-1:0] n);
        return PCNT_W'((1 << n) - 1);
    endfunction
endpackage

// File: rtl/mrt_sync_edge.sv
module mrt_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-1:0], pin};
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];

    // R7: a detected edge lasts one cycle only
    p_one_rise_r7: assert property (@(posedge clk) disable iff (rst) rise |=> !rise);
    p_one_fall_r7: assert property (@(posedge clk) disable iff (rst) fall |=> !fall);
endmodule

// File: rtl/mrt_prescaler.sv
module mrt_prescaler
    import mrt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic [PS_W-1:0] div,
    output logic            tick
);
    logic [PCNT_W-1:0] pcnt_q;
    logic [PCNT_W-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst || !run) pcnt_q <= '0;
        else             pcnt_q <= pcnt_q + PCNT_W'(1);
    end

    assign mask = div_mask(div);
    assign tick = run & ((pcnt_q & mask) == mask);

    // R5: with a divider above one, events never fall on adjacent clocks
    p_tick_gap_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && div != '0) |=> (!tick || div != $past(div)));
endmodule

// File: rtl/mrt_core.sv
module mrt_core
    import mrt_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  ctrl_t        cfg,
    input  logic [W-1:0] cmp,
    input  logic         ps_tick,
    input  logic         ext_rise,
    input  logic         clr_fall,
    input  logic         wr_cnt,
    input  logic         wr_flags,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cnt,
    output flags_t       flags
);
    logic [W-1:0] cnt_q, cnt_d;
    flags_t       flg_q, flg_d;
    logic         inc, hit, clr_ev;

    always_comb begin
        inc    = cfg.run & (cfg.src_ext ? ext_rise : ps_tick);
        hit    = inc & (cnt_q == cmp);
        clr_ev = cfg.clr_en & clr_fall;

        cnt_d = cnt_q;
        if (wr_cnt)              cnt_d = wdata;
        else if (hit || clr_ev)  cnt_d = '0;
        else if (inc)            cnt_d = cnt_q + W'(1);

        flg_d = flg_q;
        if (wr_flags) begin
            flg_d = flags_t'(wdata[1:0]);
        end else begin
            if (hit)    flg_d.match = 1'b1;
            if (clr_ev) flg_d.clr   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            flg_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            flg_q <= flg_d;
        end
    end

    assign cnt   = cnt_q;
    assign flags = flg_q;

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (inc && cnt_q != cmp && !wr_cnt && !clr_ev) |=> cnt_q == $past(cnt_q) + W'(1));
    p_match_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (hit && !wr_cnt && !wr_flags) |=> (cnt_q == '0 && flg_q.match));
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!cfg.run && !wr_cnt && !clr_ev) |=> $stable(cnt_q));
    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (flg_q.match && !wr_flags) |=> flg_q.match);
    p_clear_pin_r8: assert property (@(posedge clk) disable iff (rst)
        (clr_ev && !wr_cnt && !wr_flags) |=> (cnt_q == '0 && flg_q.clr));
    p_sw_wins_r11: assert property (@(posedge clk) disable iff (rst)
        wr_cnt |=> cnt_q == $past(wdata));
endmodule

// File: rtl/mrt_timer.sv
module mrt_timer
    import mrt_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic [1:0]    rd_addr,
    output logic [CW-1:0] rd_data,
    input  logic          cnt_pin,
    input  logic          clr_pin,
    output logic          irq
);
    localparam int CTRL_W = $bits(ctrl_t);

    ctrl_t         ctrl_q;
    logic [CW-1:0] cmp_q;
    logic [CW-1:0] cnt;
    flags_t        flags;
    logic          ps_tick, ext_rise, ext_fall_unused, clr_rise_unused, clr_fall;
    logic          wr_cnt, wr_flags;

    assign wr_cnt   = wr_en && (reg_sel_e'(wr_addr) == SEL_COUNT);
    assign wr_flags = wr_en && (reg_sel_e'(wr_addr) == SEL_FLAGS);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cmp_q  <= '1;
        end else if (wr_en) begin
            if (reg_sel_e'(wr_addr) == SEL_CTRL) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
            if (reg_sel_e'(wr_addr) == SEL_CMP)  cmp_q  <= wr_data;
        end
    end

    mrt_sync_edge #(.STAGES(2)) u_cnt_sync (
        .clk(clk), .rst(rst), .pin(cnt_pin), .rise(ext_rise), .fall(ext_fall_unused));
    mrt_sync_edge #(.STAGES(2)) u_clr_sync (
        .clk(clk), .rst(rst), .pin(clr_pin), .rise(clr_rise_unused), .fall(clr_fall));

    mrt_prescaler u_ps (
        .clk(clk), .rst(rst), .run(ctrl_q.run), .div(ctrl_q.div), .tick(ps_tick));

    mrt_core #(.W(CW)) u_core (
        .clk(clk), .rst(rst), .cfg(ctrl_q), .cmp(cmp_q), .ps_tick(ps_tick),
        .ext_rise(ext_rise), .clr_fall(clr_fall), .wr_cnt(wr_cnt),
        .wr_flags(wr_flags), .wdata(wr_data), .cnt(cnt), .flags(flags));

    always_comb begin
        unique case (reg_sel_e'(rd_addr))
            SEL_COUNT: rd_data = cnt;
            SEL_CMP:   rd_data = cmp_q;
            SEL_CTRL:  rd_data = CW'(ctrl_q);
            default:   rd_data = CW'(flags);
        endcase
    end

    assign irq = ctrl_q.irq_en & (flags.match | flags.clr);

    p_irq_gate_r10: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ctrl_q.irq_en && flags != '0));
    p_ctrl_stable_r1: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ctrl_q) && $stable(cmp_q));
endmodule

// File: tb/mrt_timer_bench.sv
module mrt_timer_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [1:0]  rd_addr = 2'd0;
    logic [15:0] rd_data;
    logic        cnt_pin = 1'b0;
    logic        clr_pin = 1'b1;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mrt_timer u_mrt_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cnt_pin(cnt_pin), .clr_pin(clr_pin),
        .irq(irq));

    typedef struct packed {
        logic [2:0]  n;
        logic [15:0] c;
        logic [15:0] w;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{3'd0, 16'd9,    16'd25},
        '{3'd1, 16'd4,    16'd11},
        '{3'd2, 16'd100,  16'd40},
        '{3'd3, 16'd2,    16'd50},
        '{3'd7, 16'd1,    16'd300},
        '{3'd0, 16'd0,    16'd5},
        '{3'd4, 16'd1000, 16'd100}
    };

    task automatic chk(input string what, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", what, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    function automatic logic [15:0] ctrl(input logic run, input logic src, input logic cen,
                                         input logic ien, input logic [2:0] n);
        return {9'd0, n, ien, cen, src, run};
    endfunction

    task automatic pulse_cnt();
        @(negedge clk) cnt_pin = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk) cnt_pin = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        rd(2'd0, v); chk("R1 reset count", v, 16'h0000);
        rd(2'd1, v); chk("R1 reset compare", v, 16'hFFFF);
        rd(2'd2, v); chk("R1 reset control", v, 16'h0000);
        rd(2'd3, v); chk("R1 reset flags", v, 16'h0000);
        chk("R10 reset irq", {15'd0, irq}, 16'd0);

        // R2 R3 R5: divided-clock table
        foreach (VECS[i]) begin
            int incs;
            logic [15:0] ecnt, eflg;
            wr(2'd2, 16'd0);
            wr(2'd0, 16'd0);
            wr(2'd3, 16'd0);
            wr(2'd1, VECS[i].c);
            wr(2'd2, ctrl(1'b1, 1'b0, 1'b0, 1'b0, VECS[i].n));
            repeat (int'(VECS[i].w)) @(posedge clk);
            @(negedge clk);
            incs = int'(VECS[i].w) >> VECS[i].n;
            ecnt = 16'(incs % (int'(VECS[i].c) + 1));
            eflg = (incs >= int'(VECS[i].c) + 1) ? 16'd1 : 16'd0;
            rd(2'd0, v); chk($sformatf("R2 R3 R5 vec%0d count", i), v, ecnt);
            rd(2'd3, v); chk($sformatf("R3 vec%0d match flag", i), v, eflg);
        end

        // R6: run cleared holds count
        wr(2'd2, 16'd0);
        wr(2'd0, 16'd42);
        repeat (20) @(posedge clk);
        @(negedge clk);
        rd(2'd0, v); chk("R6 hold while stopped", v, 16'd42);

        // R11: software write wins over counting
        wr(2'd1, 16'hFFFF);
        wr(2'd0, 16'd0);
        wr(2'd2, ctrl(1'b1, 1'b0, 1'b0, 1'b0, 3'd0));
        wr(2'd0, 16'd100);
        @(negedge clk);
        rd(2'd0, v); chk("R11 write overrides count", v, 16'd100);
        @(negedge clk);
        rd(2'd0, v); chk("R2 count resumes after write", v, 16'd101);

        // R4 R7: external count source, divider ignored
        wr(2'd2, 16'd0);
        wr(2'd0, 16'd0);
        wr(2'd2, ctrl(1'b1, 1'b1, 1'b0, 1'b0, 3'd7));
        @(negedge clk) cnt_pin = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rd(2'd0, v); chk("R7 count not yet updated", v, 16'd0);
        @(posedge clk);
        @(negedge clk);
        rd(2'd0, v); chk("R7 count after sync latency", v, 16'd1);
        repeat (10) @(posedge clk);
        @(negedge clk) cnt_pin = 1'b0;
        repeat (3) @(posedge clk);
        for (int k = 0; k < 3; k++) pulse_cnt();
        @(negedge clk);
        rd(2'd0, v); chk("R4 external pulses counted once each", v, 16'd4);

        // R8: clear pin disabled then enabled
        wr(2'd2, 16'd0);
        wr(2'd3, 16'd0);
        wr(2'd0, 16'd7);
        @(negedge clk) clr_pin = 1'b0;
        repeat (6) @(posedge clk);
        @(negedge clk);
        rd(2'd0, v); chk("R8 pin ignored count", v, 16'd7);
        rd(2'd3, v); chk("R8 pin ignored flags", v, 16'd0);
        clr_pin = 1'b1;
        repeat (4) @(posedge clk);
        wr(2'd2, ctrl(1'b0, 1'b0, 1'b1, 1'b0, 3'd0));
        @(negedge clk) clr_pin = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rd(2'd0, v); chk("R7 R8 clear not yet applied", v, 16'd7);
        @(posedge clk);
        @(negedge clk);
        rd(2'd0, v); chk("R8 clear pin zeroes count", v, 16'd0);
        rd(2'd3, v); chk("R8 clear flag set", v, 16'd2);
        @(negedge clk) clr_pin = 1'b1;
        repeat (4) @(posedge clk);

        // R9: match and clear on the same edge
        wr(2'd2, 16'd0);
        wr(2'd3, 16'd0);
        wr(2'd1, 16'd10);
        wr(2'd0, 16'd5);
        wr(2'd2, ctrl(1'b1, 1'b0, 1'b1, 1'b0, 3'd0));
        repeat (3) @(posedge clk);
        #1 clr_pin = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rd(2'd0, v); chk("R9 coincident count", v, 16'd0);
        rd(2'd3, v); chk("R9 coincident both flags", v, 16'd3);
        clr_pin = 1'b1;

        // R10: interrupt gating, R9 flag write
        wr(2'd2, ctrl(1'b0, 1'b0, 1'b0, 1'b1, 3'd0));
        @(negedge clk);
        chk("R10 irq with flags", {15'd0, irq}, 16'd1);
        wr(2'd3, 16'd0);
        @(negedge clk);
        rd(2'd3, v); chk("R9 flags cleared by write", v, 16'd0);
        chk("R10 irq low without flags", {15'd0, irq}, 16'd0);
        wr(2'd3, 16'd2);
        @(negedge clk);
        chk("R10 irq on clear flag", {15'd0, irq}, 16'd1);
        wr(2'd2, 16'd0);
        @(negedge clk);
        chk("R10 irq masked", {15'd0, irq}, 16'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule